// File: doc/BRIEF.md
# Dual Converter Master/Slave Coordinator

This block sits between two converter sequencers, one designated master and one slave, and decides when each one starts and how their results leave the block. A two-bit mode input selects one of four behaviours: the two converters run on their own triggers, they run in lockstep on one trigger, or they take turns on the same input with a fixed fast or slow spacing. Both converters are modelled as behavioural stubs. Each captures its sample input on start, reports done a fixed number of converter-clock periods later, and holds its result until the coordinator takes it. A single clock-enable input, `tick_i`, marks every converter-clock period.

In lockstep mode the master trigger launches both converters in the same cycle. The coordinator waits for the later of the two to finish and then delivers one 32-bit word with a one-cycle ready pulse, which serves as the transfer request. In the two alternating modes the master trigger launches the slave at once and the master a fixed number of converter clocks later. The group is a single channel in both alternating modes, and the slow mode allows no other size. Outside lockstep mode each result leaves on its own port with a tag naming its source. A mode request takes effect only when the whole block is idle.

Top module: `dual_conv_coord`

## Requirements
- R1: After reset `word_vld_o`, `res_vld_o` and `word_o` are 0, and `mode_o` reads 0 (independent).
- R2: In mode 0 (independent) `mst_start_o` follows `mst_trig_i` and `slv_start_o` follows `slv_trig_i` in the same cycle. Each result is delivered alone on `res_o` with `res_src_o` = 0 for the master and 1 for the slave, and `word_vld_o` stays low.
- R3: In mode 1 (simultaneous) `mst_trig_i` starts both converters in the same cycle, and `slv_trig_i` starts nothing.
- R4: In mode 1 `word_o` carries the master result in bits 15:0 and the slave result in bits 31:16. `word_vld_o` pulses for one cycle per pair, only after both converters have finished, and the earlier result is held until then.
- R5: In mode 2 (fast alternating) `mst_trig_i` starts the slave in the same cycle. The master starts on the 7th `tick_i` period after that cycle.
- R6: In mode 3 (slow alternating) the master starts on the 14th `tick_i` period after the slave.
- R7: In the alternating modes each converter's result is delivered alone on `res_o`, tagged with its source, in the order the conversions complete.
- R8: A new value on `mode_i` is adopted (seen on `mode_o`) only while both converters and the spacing timer are idle. While work is in flight it is deferred.
- R9: A trigger that arrives while the targeted converter is busy is ignored. It does not restart the conversion or change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One pulse per converter-clock period |
| mode_i | input | 2 | Requested mode: 0 independent, 1 simultaneous, 2 fast alternating, 3 slow alternating |
| mst_trig_i | input | 1 | Master regular trigger (already selected) |
| slv_trig_i | input | 1 | Slave regular trigger, used in mode 0 only |
| mst_sample_i | input | 16 | Value the master stub converts |
| slv_sample_i | input | 16 | Value the slave stub converts |
| mst_start_o | output | 1 | Start issued to the master converter |
| slv_start_o | output | 1 | Start issued to the slave converter |
| mode_o | output | 2 | Mode currently in force |
| word_o | output | 32 | Packed pair: slave high, master low |
| word_vld_o | output | 1 | Packed word ready / transfer request pulse |
| res_o | output | 16 | Single result outside simultaneous mode |
| res_src_o | output | 1 | Source of `res_o`: 0 master, 1 slave |
| res_vld_o | output | 1 | `res_o` valid pulse |

## Verification
The slave stub finishes several converter clocks before the master, so a packer that fires on the first done would emit a word with a stale master half. The bench catches this through the tick count to `word_vld_o` and through the scoreboard word. The bench counts converter-clock ticks between the slave and master starts in both alternating modes, which exposes an off-by-one or swapped spacing. It changes the mode while a conversion runs, so a coordinator that switches early loses or misroutes a result. It also pulses the slave trigger in lockstep mode and re-triggers a busy converter, so any stray start shows up as an extra result or a changed value.

// File: rtl/dual_conv_pkg.sv
package dual_conv_pkg;
  typedef enum logic [1:0] {
    MODE_INDEP   = 2'd0,
    MODE_SIMUL   = 2'd1,
    MODE_FAST_IL = 2'd2,
    MODE_SLOW_IL = 2'd3
  } dmode_e;
endpackage

// File: rtl/conv_stub.sv
module conv_stub #(
  parameter int unsigned DW    = 16,
  parameter int unsigned TICKS = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [DW-1:0] sample_i,
  input  logic          ack_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  typedef enum logic [1:0] {C_IDLE, C_RUN, C_DONE} cst_e;

  cst_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= C_IDLE;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        C_IDLE: if (start_i) begin
          st_q   <= C_RUN;
          cnt_q  <= CW'(TICKS);
          data_q <= sample_i;
        end
        C_RUN: if (tick_i) begin
          if (cnt_q == CW'(1)) st_q <= C_DONE;
          else                 cnt_q <= cnt_q - CW'(1);
        end
        C_DONE: if (ack_i) st_q <= C_IDLE;
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == C_IDLE);
  assign done_o = (st_q == C_DONE);
  assign data_o = data_q;

  // R9
  run_result_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_RUN) |=> $stable(data_q));
  // R7
  ack_only_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (st_q == C_DONE));
endmodule

// File: rtl/il_spacer.sv
module il_spacer #(
  parameter int unsigned FAST_GAP = 7,
  parameter int unsigned SLOW_GAP = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic launch_i,
  input  logic slow_i,
  output logic fire_o,
  output logic idle_o
);
  localparam int unsigned MAXG = (FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP;
  localparam int unsigned CW   = $clog2(MAXG + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= slow_i ? CW'(SLOW_GAP) : CW'(FAST_GAP);
    end else if (busy_q && tick_i) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign fire_o = busy_q && tick_i && (cnt_q == CW'(1));
  assign idle_o = !busy_q;

  // R5
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> $stable(cnt_q));
  // R6
  launch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q);
endmodule

// File: rtl/dual_conv_coord.sv
module dual_conv_coord
  import dual_conv_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned MST_TICKS = 12,
  parameter int unsigned SLV_TICKS = 9,
  parameter int unsigned FAST_GAP  = 7,
  parameter int unsigned SLOW_GAP  = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [1:0]      mode_i,
  input  logic            mst_trig_i,
  input  logic            slv_trig_i,
  input  logic [DW-1:0]   mst_sample_i,
  input  logic [DW-1:0]   slv_sample_i,
  output logic            mst_start_o,
  output logic            slv_start_o,
  output logic [1:0]      mode_o,
  output logic [2*DW-1:0] word_o,
  output logic            word_vld_o,
  output logic [DW-1:0]   res_o,
  output logic            res_src_o,
  output logic            res_vld_o
);
  localparam int unsigned WW = 2 * DW;

  dmode_e        act_q;
  logic          m_idle, m_done, m_ack, s_idle, s_done, s_ack;
  logic [DW-1:0] m_data, s_data;
  logic          sp_idle, sp_fire, sp_launch;
  logic          is_indep, is_simul, is_il, pair_go, pack_go, idle_all;

  assign is_indep = (act_q == MODE_INDEP);
  assign is_simul = (act_q == MODE_SIMUL);
  assign is_il    = (act_q == MODE_FAST_IL) || (act_q == MODE_SLOW_IL);
  assign idle_all = m_idle && s_idle && sp_idle;
  assign pair_go  = mst_trig_i && idle_all && !is_indep;

  assign mst_start_o = is_indep ? (mst_trig_i && m_idle) : (is_simul ? pair_go : sp_fire);
  assign slv_start_o = is_indep ? (slv_trig_i && s_idle) : pair_go;
  assign sp_launch   = is_il && pair_go;

  assign pack_go = is_simul && m_done && s_done;
  assign m_ack   = is_simul ? pack_go : m_done;
  assign s_ack   = is_simul ? pack_go : (s_done && !m_done);

  conv_stub #(.DW(DW), .TICKS(MST_TICKS)) u_mst (
    .clk_i, .rst_ni, .tick_i,
    .start_i(mst_start_o), .sample_i(mst_sample_i), .ack_i(m_ack),
    .idle_o(m_idle), .done_o(m_done), .data_o(m_data)
  );

  conv_stub #(.DW(DW), .TICKS(SLV_TICKS)) u_slv (
    .clk_i, .rst_ni, .tick_i,
    .start_i(slv_start_o), .sample_i(slv_sample_i), .ack_i(s_ack),
    .idle_o(s_idle), .done_o(s_done), .data_o(s_data)
  );

  il_spacer #(.FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP)) u_gap (
    .clk_i, .rst_ni, .tick_i,
    .launch_i(sp_launch), .slow_i(act_q == MODE_SLOW_IL),
    .fire_o(sp_fire), .idle_o(sp_idle)
  );

  // mode switch only with nothing in flight and nothing starting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= MODE_INDEP;
    else if (idle_all && !mst_start_o && !slv_start_o) act_q <= dmode_e'(mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o     <= '0;
      word_vld_o <= 1'b0;
      res_o      <= '0;
      res_src_o  <= 1'b0;
      res_vld_o  <= 1'b0;
    end else begin
      word_vld_o <= pack_go;
      res_vld_o  <= 1'b0;
      if (pack_go) word_o <= WW'({s_data, m_data});
      if (!is_simul && m_done) begin
        res_o     <= m_data;
        res_src_o <= 1'b0;
        res_vld_o <= 1'b1;
      end else if (!is_simul && s_done) begin
        res_o     <= s_data;
        res_src_o <= 1'b1;
        res_vld_o <= 1'b1;
      end
    end
  end

  assign mode_o = act_q;

  // R3
  simul_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_simul && mst_start_o) |-> slv_start_o);
  // R4
  pack_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(m_done && s_done));
  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_all |=> $stable(act_q));
  // R9
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_start_o |-> m_idle) and (slv_start_o |-> s_idle));
  // R2
  one_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({word_vld_o, res_vld_o}));
endmodule

// File: tb/dual_conv_coord_tb_top.sv
module dual_conv_coord_tb_top;
  localparam int unsigned DW = 16, MST_T = 12, SLV_T = 9;

  typedef struct packed {
    logic        is_word;
    logic [31:0] data;
    logic        src;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic mst_trig_i = 1'b0, slv_trig_i = 1'b0;
  logic [DW-1:0] mst_sample_i = '0, slv_sample_i = '0;
  logic mst_start_o, slv_start_o, word_vld_o, res_src_o, res_vld_o;
  logic [1:0] mode_o;
  logic [31:0] word_o;
  logic [DW-1:0] res_o;

  int checks = 0, fails = 0;
  exp_t sb_q[$];
  int exp_gap = 0;
  bit gap_on = 0, pk_on = 0, ended = 0;
  int gcnt = 0, pkcnt = 0;
  logic [1:0] tdiv = '0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
    tick_i <= (tdiv == 2'd2);
  end

  dual_conv_coord dut_i (
    .clk_i(clk), .rst_ni, .tick_i, .mode_i, .mst_trig_i, .slv_trig_i,
    .mst_sample_i, .slv_sample_i, .mst_start_o, .slv_start_o, .mode_o,
    .word_o, .word_vld_o, .res_o, .res_src_o, .res_vld_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit mt, input bit st, input logic [DW-1:0] ms, input logic [DW-1:0] ss,
                       output logic ms_o, output logic ss_o);
    @(posedge clk); #1;
    mst_sample_i = ms; slv_sample_i = ss;
    mst_trig_i = mt; slv_trig_i = st;
    @(negedge clk);
    ms_o = mst_start_o; ss_o = slv_start_o;
    @(posedge clk); #1;
    mst_trig_i = 1'b0; slv_trig_i = 1'b0;
  endtask

  task automatic push(input bit w, input logic [31:0] d, input bit s);
    exp_t e;
    e.is_word = w; e.data = d; e.src = s;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: scoreboard and tick-spacing checks
  always @(negedge clk) begin
    if (rst_ni) begin
      if (res_vld_o || word_vld_o) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2/R9 unexpected output", {15'd0, word_vld_o, res_o}, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (e.is_word) begin
            chk(word_vld_o && word_o == e.data, "R4 packed word", word_o, e.data);
          end else begin
            chk(res_vld_o && res_o == e.data[15:0], "R7 result value", {16'd0, res_o}, e.data);
            chk(res_src_o == e.src, "R7 result source tag", {31'd0, res_src_o}, {31'd0, e.src});
          end
        end
      end
      if (slv_start_o && mode_o[1]) begin
        gap_on = 1; gcnt = 0;
      end else if (gap_on) begin
        if (tick_i) gcnt++;
        if (mst_start_o) begin
          chk(gcnt == exp_gap && tick_i, exp_gap == 7 ? "R5 fast spacing" : "R6 slow spacing",
              gcnt, exp_gap);
          gap_on = 0;
        end
      end
      if (mst_start_o && mode_o == 2'd1) begin
        pk_on = 1; pkcnt = 0;
      end else if (pk_on) begin
        if (tick_i) pkcnt++;
        if (word_vld_o) begin
          chk(pkcnt == MST_T, "R4 packed after later converter", pkcnt, MST_T);
          pk_on = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ms, ss;
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(!word_vld_o && !res_vld_o, "R1 valids low", {word_vld_o, res_vld_o}, 0);
    chk(word_o == 0, "R1 word zero", word_o, 0);
    chk(mode_o == 2'd0, "R1 independent mode", mode_o, 0);

    // R2 independent
    push(0, 32'h0111, 0);
    pulse(1, 0, 16'h0111, 16'h0, ms, ss);
    chk(ms && !ss, "R2 master start follows trigger", {ms, ss}, 2'b10);
    idle(60);
    push(0, 32'h0222, 1);
    pulse(0, 1, 16'h0, 16'h0222, ms, ss);
    chk(!ms && ss, "R2 slave start follows trigger", {ms, ss}, 2'b01);
    idle(60);
    // both at once: slave shorter, finishes first
    push(0, 32'h0444, 1);
    push(0, 32'h0333, 0);
    pulse(1, 1, 16'h0333, 16'h0444, ms, ss);
    chk(ms && ss, "R2 both start", {ms, ss}, 2'b11);
    idle(6);
    // R9 retrigger of busy master ignored
    pulse(1, 0, 16'h0999, 16'h0, ms, ss);
    chk(!ms, "R9 busy master not restarted", ms, 0);
    idle(60);

    // R8 deferral
    push(0, 32'h0555, 0);
    pulse(1, 0, 16'h0555, 16'h0, ms, ss);
    mode_i = 2'd1;
    idle(5);
    @(negedge clk);
    chk(mode_o == 2'd0, "R8 mode deferred while busy", mode_o, 0);
    idle(60);
    @(negedge clk);
    chk(mode_o == 2'd1, "R8 mode adopted when idle", mode_o, 1);

    // R3/R4 simultaneous
    push(1, 32'hABCD1234, 0);
    pulse(1, 0, 16'h1234, 16'hABCD, ms, ss);
    chk(ms && ss, "R3 both start on master trigger", {ms, ss}, 2'b11);
    idle(60);
    pulse(0, 1, 16'h0, 16'h7777, ms, ss);
    chk(!ms && !ss, "R3 slave trigger ignored", {ms, ss}, 2'b00);
    idle(60);
    push(1, 32'h00FFF000, 0);
    pulse(1, 0, 16'hF000, 16'h00FF, ms, ss);
    idle(60);

    // R5 fast alternating
    mode_i = 2'd2;
    idle(3);
    exp_gap = 7;
    push(0, 32'h0BBB, 1);
    push(0, 32'h0AAA, 0);
    pulse(1, 0, 16'h0AAA, 16'h0BBB, ms, ss);
    chk(!ms && ss, "R5 slave first", {ms, ss}, 2'b01);
    idle(90);

    // R6 slow alternating
    mode_i = 2'd3;
    idle(3);
    @(negedge clk);
    chk(mode_o == 2'd3, "R8 slow mode adopted", mode_o, 3);
    exp_gap = 14;
    push(0, 32'h0DDD, 1);
    push(0, 32'h0CCC, 0);
    pulse(1, 0, 16'h0CCC, 16'h0DDD, ms, ss);
    chk(!ms && ss, "R6 slave first", {ms, ss}, 2'b01);
    idle(120);

    chk(sb_q.size() == 0, "R7 all results delivered", sb_q.size(), 0);
    chk(!gap_on && !pk_on, "R5 spacing observed", {gap_on, pk_on}, 0);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule